// File: doc/BRIEF.md
# Rate-Paced Parallel Word Streamer

This block reads words from one of two synchronous source memories and presents them on a 32-bit parallel output bus. The rate at which they appear is set by a number-controlled oscillator. A 31-bit phase register adds a 32-bit rate increment on every clock. Each time the sum reaches 2^31 or more, one element goes out, and the bit at position 31 is then discarded. Elements can be bytes, 16-bit halves or full 32-bit words. Narrow elements are unpacked from each fetched memory word, lowest lane first.

Software-side logic loads a rate, an element size, a source choice, a start address and an element count. It then pulses start. The block primes itself with the first memory word and paces out the elements. It raises a done flag after the last one. A stop pulse abandons a run at once.

Top module: `nco_streamer`

## Requirements
- R1: While reset is asserted and just after it, outValid, busy and doneFlag are 0 and outData is all zeros.
- R2: A start pulse, sampled while the block is not busy, does four things. It latches rateInc, sizeSel, srcSel, baseAddr and xferCount, and clears the phase register. If the count is non-zero, it issues a read of baseAddr to the selected memory in that same cycle and raises busy after the edge.
- R3: The phase register takes its first addition on the second clock edge after the start edge. From then on it adds the increment on every edge. A transfer happens on each edge where phase plus increment is at least 2^31, and the phase then keeps only the low 31 bits of the sum.
- R4: An increment of 0x8000_0000 gives a transfer on every edge from the second edge after start. An increment of 0x4000_0000 gives a transfer on every second edge.
- R5: An increment of 0x2AAA_AAAB gives its first transfer on the third addition and one on every third edge after that. The value 0x2AAA_AAAA, which has the low bit clear, gives its first transfer only on the fourth addition.
- R6: sizeSel encodes the element size: 0 is byte, 1 is 16-bit half, and 2 or 3 is 32-bit word. Byte and half elements sit in the low bits of outData, with all upper bits 0.
- R7: Elements are taken from consecutive memory words starting at baseAddr. Within a word they come in ascending lane order: bytes 0,1,2,3 from bit 0 upward, or halves 0,1. The address moves to the next word only after the last lane is used.
- R8: srcSel 0 reads the main memory and srcSel 1 reads the lookup memory. The read enable of the memory not selected stays 0 for the whole run.
- R9: After exactly xferCount transfers, doneFlag rises on the edge of the last transfer and busy falls. doneFlag then stays high until the next start. A count of 0 raises doneFlag on the start edge and produces no transfer.
- R10: outValid is high for exactly one clock after each transfer edge and low otherwise. outData changes only on transfer edges.
- R11: A stop pulse while busy ends the run on that edge. No transfer happens on that edge or later, busy falls, and doneFlag stays 0.
- R12: A start pulse while busy is ignored. The run continues with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Begin a run with the present settings |
| stopPulse | input | 1 | Abandon the current run |
| rateInc | input | 32 | Phase increment per clock |
| sizeSel | input | 2 | Element size select |
| srcSel | input | 1 | Source memory select (0 main, 1 lookup) |
| baseAddr | input | ADDR_W | Word address of the first element |
| xferCount | input | CNT_W | Number of elements to send |
| mainRdEn | output | 1 | Main memory read enable |
| mainRdAddr | output | ADDR_W | Main memory read address |
| mainRdData | input | 32 | Main memory read data, one cycle after the address |
| lutRdEn | output | 1 | Lookup memory read enable |
| lutRdAddr | output | ADDR_W | Lookup memory read address |
| lutRdData | input | 32 | Lookup memory read data, one cycle after the address |
| outData | output | 32 | Parallel output bus |
| outValid | output | 1 | One-clock strobe marking new output data |
| busy | output | 1 | Run in progress |
| doneFlag | output | 1 | Last run finished its count |

## Verification
The start read is combinational, so its enable and address are checked in the start cycle itself, before the start edge. Every other result is registered. A transfer decided at edge n shows on outValid, outData, doneFlag and busy in the cycle after that edge. Counting the start edge as edge 0, the first possible transfer edge is 2, because edge 1 only loads the first word. The bench drives inputs and samples outputs at the falling edge. It steps a phase model of its own once per rising edge from edge 2 onward, and it compares every cycle of every run against that model, including stop and intruding-start cycles.

// File: rtl/streamer_pkg.sv
package streamer_pkg;
  localparam int WORD_W = 32;
  localparam int PHASE_W = 31;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } streamStateT;

  typedef struct packed {
    logic startLd;    // accepted start with non-zero count
    logic primeStep;  // first word arriving from memory
    logic running;    // phase register advances
    logic xfer;       // emit one element this edge
  } streamStrbT;
endpackage

// File: rtl/stream_phase.sv
module stream_phase
  import streamer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              step,
  input  logic [WORD_W-1:0] rateInc,
  output logic              fire
);
  logic [PHASE_W-1:0] phase;
  logic [WORD_W-1:0]  incReg;
  logic [WORD_W:0]    sum;

  always_comb begin
    sum  = {2'b00, phase} + {1'b0, incReg};
    fire = step && (sum[WORD_W:PHASE_W] != 2'b00);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      incReg <= '0;
    end else if (clear) begin
      phase  <= '0;
      incReg <= rateInc;
    end else if (step) begin
      phase  <= sum[PHASE_W-1:0];
    end
  end
endmodule

// File: rtl/stream_ctrl.sv
module stream_ctrl
  import streamer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic       countZero,
  input  logic       fire,
  input  logic       finalXfer,
  output streamStrbT strb,
  output logic       busy,
  output logic       doneFlag
);
  streamStateT state, stateNext;
  logic accept;

  always_comb begin
    accept         = startPulse && (state == ST_IDLE || state == ST_DONE);
    strb.startLd   = accept && !countZero;
    strb.primeStep = (state == ST_PRIME);
    strb.running   = (state == ST_RUN);
    strb.xfer      = (state == ST_RUN) && fire && !stopPulse;

    stateNext = state;
    case (state)
      ST_IDLE, ST_DONE: if (accept) stateNext = countZero ? ST_DONE : ST_PRIME;
      ST_PRIME:         stateNext = stopPulse ? ST_IDLE : ST_RUN;
      ST_RUN: begin
        if (stopPulse)                  stateNext = ST_IDLE;
        else if (strb.xfer && finalXfer) stateNext = ST_DONE;
      end
      default:          stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy     = (state == ST_PRIME) || (state == ST_RUN);
  assign doneFlag = (state == ST_DONE);
endmodule

// File: rtl/stream_dpath.sv
module stream_dpath
  import streamer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  streamStrbT        strb,
  input  logic [1:0]        sizeSel,
  input  logic              srcSel,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  xferCount,
  input  logic [WORD_W-1:0] mainRdData,
  input  logic [WORD_W-1:0] lutRdData,
  output logic              finalXfer,
  output logic              mainRdEn,
  output logic [ADDR_W-1:0] mainRdAddr,
  output logic              lutRdEn,
  output logic [ADDR_W-1:0] lutRdAddr,
  output logic [WORD_W-1:0] outData,
  output logic              outValid
);
  localparam int LANE_W = 2;

  logic [1:0]        cfgSize;
  logic              cfgSrc;
  logic [CNT_W-1:0]  remaining;
  logic [ADDR_W-1:0] fetchAddr;
  logic [WORD_W-1:0] curWord, nextWord;
  logic              nextValid, pendRd;
  logic [LANE_W-1:0] laneIdx, lanesM1;

  logic              lastLane, consumeLast, readNow, useLut;
  logic [ADDR_W-1:0] rdAddr;
  logic [WORD_W-1:0] rdData, shifted, element;

  always_comb begin
    case (cfgSize)
      SIZE_BYTE: lanesM1 = 2'd3;
      SIZE_HALF: lanesM1 = 2'd1;
      default:   lanesM1 = 2'd0;
    endcase
    lastLane    = (laneIdx == lanesM1);
    consumeLast = strb.xfer && lastLane;
    readNow     = strb.startLd || strb.primeStep || consumeLast;
    rdAddr      = strb.startLd ? baseAddr : fetchAddr;
    useLut      = strb.startLd ? srcSel : cfgSrc;
    rdData      = cfgSrc ? lutRdData : mainRdData;

    case (cfgSize)
      SIZE_BYTE: begin
        shifted = curWord >> {laneIdx, 3'b000};
        element = {24'b0, shifted[7:0]};
      end
      SIZE_HALF: begin
        shifted = curWord >> {laneIdx[0], 4'b0000};
        element = {16'b0, shifted[15:0]};
      end
      default: begin
        shifted = curWord;
        element = curWord;
      end
    endcase
    finalXfer = (remaining == CNT_W'(1));
  end

  assign mainRdEn   = readNow && !useLut;
  assign lutRdEn    = readNow && useLut;
  assign mainRdAddr = rdAddr;
  assign lutRdAddr  = rdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSize   <= '0;
      cfgSrc    <= 1'b0;
      remaining <= '0;
      fetchAddr <= '0;
      curWord   <= '0;
      nextWord  <= '0;
      nextValid <= 1'b0;
      pendRd    <= 1'b0;
      laneIdx   <= '0;
      outData   <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strb.xfer;
      if (strb.startLd) begin
        cfgSize   <= sizeSel;
        cfgSrc    <= srcSel;
        remaining <= xferCount;
        fetchAddr <= baseAddr + ADDR_W'(1);
        laneIdx   <= '0;
        nextValid <= 1'b0;
        pendRd    <= 1'b0;
      end else if (strb.primeStep) begin
        curWord   <= rdData;
        fetchAddr <= fetchAddr + ADDR_W'(1);
        pendRd    <= 1'b1;
        nextValid <= 1'b0;
      end else begin
        if (strb.xfer) begin
          outData   <= element;
          remaining <= remaining - CNT_W'(1);
          if (lastLane) begin
            laneIdx   <= '0;
            curWord   <= nextValid ? nextWord : rdData;
            nextValid <= 1'b0;
            pendRd    <= 1'b1;
            fetchAddr <= fetchAddr + ADDR_W'(1);
          end else begin
            laneIdx   <= laneIdx + LANE_W'(1);
          end
        end
        if (!consumeLast && pendRd) begin
          nextWord  <= rdData;
          nextValid <= 1'b1;
          pendRd    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/nco_streamer.sv
module nco_streamer
  import streamer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic [31:0]       rateInc,
  input  logic [1:0]        sizeSel,
  input  logic              srcSel,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  xferCount,
  output logic              mainRdEn,
  output logic [ADDR_W-1:0] mainRdAddr,
  input  logic [31:0]       mainRdData,
  output logic              lutRdEn,
  output logic [ADDR_W-1:0] lutRdAddr,
  input  logic [31:0]       lutRdData,
  output logic [31:0]       outData,
  output logic              outValid,
  output logic              busy,
  output logic              doneFlag
);
  streamStrbT strb;
  logic fire, finalXfer, countZero;

  assign countZero = (xferCount == '0);

  stream_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .countZero(countZero), .fire(fire), .finalXfer(finalXfer),
    .strb(strb), .busy(busy), .doneFlag(doneFlag)
  );

  stream_phase u_phase (
    .clk(clk), .rstN(rstN), .clear(strb.startLd), .step(strb.running),
    .rateInc(rateInc), .fire(fire)
  );

  stream_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sizeSel(sizeSel), .srcSel(srcSel),
    .baseAddr(baseAddr), .xferCount(xferCount),
    .mainRdData(mainRdData), .lutRdData(lutRdData), .finalXfer(finalXfer),
    .mainRdEn(mainRdEn), .mainRdAddr(mainRdAddr),
    .lutRdEn(lutRdEn), .lutRdAddr(lutRdAddr),
    .outData(outData), .outValid(outValid)
  );
endmodule

// File: rtl/stream_sva.sv
module stream_sva (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic stopPulse,
  input logic busy,
  input logic doneFlag,
  input logic outValid,
  input logic mainRdEn,
  input logic lutRdEn
);
  // R8: never both memories in one cycle
  a_r8_one_source: assert property (@(posedge clk) disable iff (!rstN)
    !(mainRdEn && lutRdEn));

  // R11: stop while busy ends the run with no output on that edge
  a_r11_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stopPulse) |=> (!busy && !outValid && !doneFlag));

  // R9: done persists until a new start
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !startPulse) |=> doneFlag);

  // R10: strobe only follows a cycle of an active run
  a_r10_valid_in_run: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(busy));

  // R9: no output once done has been seen for a full cycle
  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && $past(doneFlag)) |-> !outValid);
endmodule

bind nco_streamer stream_sva u_sva (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
  .busy(busy), .doneFlag(doneFlag), .outValid(outValid),
  .mainRdEn(mainRdEn), .lutRdEn(lutRdEn)
);

// File: tb/sim_nco_streamer.sv
module sim_nco_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0, stopPulse = 1'b0;
  logic [31:0] rateInc = '0;
  logic [1:0]  sizeSel = '0;
  logic        srcSel = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [CNT_W-1:0]  xferCount = '0;
  logic mainRdEn, lutRdEn, outValid, busy, doneFlag;
  logic [ADDR_W-1:0] mainRdAddr, lutRdAddr;
  logic [31:0] mainRdData = '0, lutRdData = '0, outData;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_streamer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .rateInc(rateInc), .sizeSel(sizeSel), .srcSel(srcSel),
    .baseAddr(baseAddr), .xferCount(xferCount),
    .mainRdEn(mainRdEn), .mainRdAddr(mainRdAddr), .mainRdData(mainRdData),
    .lutRdEn(lutRdEn), .lutRdAddr(lutRdAddr), .lutRdData(lutRdData),
    .outData(outData), .outValid(outValid), .busy(busy), .doneFlag(doneFlag)
  );

  function automatic logic [31:0] memWord(bit lut, logic [ADDR_W-1:0] a);
    if (lut) return {a, ~a, a ^ 8'h5A, a + 8'd7};
    return 32'h1357_9BDF ^ {a + 8'd3, a + 8'd2, a + 8'd1, a};
  endfunction

  function automatic logic [31:0] expElem(bit lut, logic [ADDR_W-1:0] base,
                                          logic [1:0] sz, int idx);
    int lanes = (sz == 2'd0) ? 4 : (sz == 2'd1) ? 2 : 1;
    logic [31:0] w = memWord(lut, base + ADDR_W'(idx / lanes));
    int ln = idx % lanes;
    if (sz == 2'd0) return {24'b0, w[ln*8 +: 8]};
    if (sz == 2'd1) return {16'b0, w[ln*16 +: 16]};
    return w;
  endfunction

  always @(posedge clk) begin
    if (mainRdEn) mainRdData <= memWord(1'b0, mainRdAddr);
    if (lutRdEn)  lutRdData  <= memWord(1'b1, lutRdAddr);
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  // One run against an independent per-edge phase model.
  task automatic runStream(logic [31:0] inc, logic [1:0] sz, bit src,
                           logic [ADDR_W-1:0] base, int count, int stopAt,
                           int intrudeAt, string rateTag);
    logic [31:0] held;
    logic [32:0] s;
    logic [30:0] acc = '0;
    int emitted = 0;
    int extra = 0;
    bit stopped = 0;
    bit expV;
    logic [31:0] expD;
    @(negedge clk);
    held = outData;
    rateInc = inc; sizeSel = sz; srcSel = src; baseAddr = base;
    xferCount = CNT_W'(count);
    startPulse = 1'b1;
    #1;
    if (count != 0) begin
      chk(src ? (lutRdEn && lutRdAddr == base) : (mainRdEn && mainRdAddr == base),
          "R2 start read", {src ? lutRdAddr : mainRdAddr}, {24'b0, base});
    end
    @(negedge clk);
    startPulse = 1'b0;
    chk(busy == (count != 0), "R2 busy", {31'b0, busy}, {31'b0, count != 0});
    chk(doneFlag == (count == 0), "R9 zero count", {31'b0, doneFlag}, {31'b0, count == 0});
    chk(outValid == 1'b0, "R10 no early strobe", {31'b0, outValid}, 32'd0);
    for (int n = 1; n < 5000; n++) begin
      if (n == stopAt) stopPulse = 1'b1;
      if (n == intrudeAt) begin
        startPulse = 1'b1; rateInc = 32'h8000_0000; sizeSel = 2'd2;
        srcSel = ~src; baseAddr = base + 8'd40; xferCount = CNT_W'(1);
      end
      @(negedge clk);
      stopPulse = 1'b0; startPulse = 1'b0;
      expV = 1'b0; expD = held;
      if (!stopped && emitted < count && n == stopAt) stopped = 1;
      else if (!stopped && emitted < count && n >= 2) begin
        s = {2'b00, acc} + {1'b0, inc};
        acc = s[30:0];
        if (s >= 33'h0_8000_0000) begin
          expD = expElem(src, base, sz, emitted);
          held = expD;
          expV = 1'b1;
          emitted++;
        end
      end
      chk(outValid == expV, rateTag, {31'b0, outValid}, {31'b0, expV});
      chk(outData == expD, expV ? "R6 R7 element" : "R10 data held", outData, expD);
      chk(doneFlag == (!stopped && emitted == count), stopped ? "R11 no done" : "R9 done",
          {31'b0, doneFlag}, {31'b0, !stopped && emitted == count});
      chk(busy == (!stopped && emitted < count), intrudeAt > 0 ? "R12 busy" : "R11 busy",
          {31'b0, busy}, {31'b0, !stopped && emitted < count});
      chk(src ? !mainRdEn : !lutRdEn, "R8 other source idle",
          {31'b0, src ? mainRdEn : lutRdEn}, 32'd0);
      if (stopped || emitted == count) begin
        extra++;
        if (extra > 4) break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!outValid && !busy && !doneFlag && outData == '0, "R1 reset",
        {outData[28:0], outValid, busy, doneFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !busy && !doneFlag, "R1 after release",
        {29'b0, outValid, busy, doneFlag}, 32'd0);

    runStream(32'h8000_0000, 2'd2, 1'b0, 8'h10, 6, 0, 0, "R4 every clock");
    runStream(32'h4000_0000, 2'd0, 1'b1, 8'h20, 9, 0, 0, "R4 every second");
    runStream(32'h2AAA_AAAB, 2'd1, 1'b0, 8'hFE, 7, 0, 0, "R5 every third");
    runStream(32'h2AAA_AAAA, 2'd0, 1'b0, 8'h33, 6, 0, 0, "R5 low bit clear");
    runStream(32'hFFFF_FFFF, 2'd3, 1'b1, 8'h05, 5, 0, 0, "R3 max rate");
    runStream(32'h8000_0000, 2'd0, 1'b0, 8'h40, 11, 0, 0, "R7 byte lanes");
    runStream(32'h1000_0000, 2'd1, 1'b1, 8'h50, 0, 0, 0, "R9 zero count");
    runStream(32'h3000_0000, 2'd0, 1'b0, 8'h60, 12, 9, 0, "R11 stop");
    runStream(32'h8000_0000, 2'd2, 1'b1, 8'h70, 4, 1, 0, "R11 stop in prime");
    runStream(32'h2000_0000, 2'd1, 1'b0, 8'h80, 6, 0, 5, "R12 start ignored");

    void'($urandom(32'd2024));
    for (int r = 0; r < 12; r++) begin
      logic [31:0] inc = 32'h0800_0000 + ($urandom % 32'h9000_0000);
      runStream(inc, 2'($urandom % 4), 1'($urandom % 2), 8'($urandom),
                1 + int'($urandom % 20), 0, 0, "R3 random rate");
    end

    summary();
    $finish;
  end
endmodule